// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block turns a digital supply-low indication from an external voltage comparator into a chip-level reset. The comparator output is asynchronous. It is synchronized, and it must stay active for a minimum number of clock cycles before the block enters its brown-out state. Reset is held for as long as the supply stays low. After the supply recovers, reset is held for a fixed power-up delay and is then released.

If the supply drops again while the power-up delay is running, the block goes back to the brown-out state. The delay timer is discarded, and the next recovery counts the full delay again from zero. A configuration enable turns the whole function off. A sticky status flag records that a brown-out reset took place, and it is cleared by a single-cycle clear pulse. After power-on reset, the block starts in the power-up delay with reset asserted. The delay and the qualification time are derived from a clock-frequency parameter, and each can be overridden directly in cycles.

Top module: `bor_sequencer`

## Requirements
- R1: When `bor_en` is 0, `supply_low_a` has no effect: `rst_out` stays 0 and `bor_flag` stays 0 while the block is running.
- R2: `supply_low_a` passes through a two-flop synchronizer. A brown-out is entered only after the synchronized indication has been 1 on QUAL_CYC consecutive clock edges. A pulse held for fewer cycles leaves `rst_out` at 0.
- R3: In the brown-out state, `rst_out` stays 1 for as long as the synchronized supply-low indication stays 1.
- R4: Every entry into the brown-out state sets `bor_flag` to 1 on the same edge at which `rst_out` rises.
- R5: The block moves to the delay state on the edge after the synchronized indication falls. `rst_out` stays 1 for DELAY_CYC more clock edges and falls on the edge at which the delay counter reaches DELAY_CYC-1.
- R6: If the synchronized indication returns to 1 (with `bor_en`=1) during the delay, the block re-enters the brown-out state at once. The next recovery counts a full DELAY_CYC from zero.
- R7: The qualification count restarts from zero whenever the synchronized indication is 0 before the threshold is reached. Two short pulses separated by a gap therefore do not add together.
- R8: While `por_n` is 0, `rst_out` is 1 and `bor_flag` is 0. After release, the block runs the delay state, so `rst_out` falls after DELAY_CYC clock edges.
- R9: A one-cycle pulse on `flag_clr` clears `bor_flag` on the next edge, as long as no brown-out entry happens on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low_a | input | 1 | Asynchronous supply-low indication from the comparator |
| bor_en | input | 1 | Configuration enable for the brown-out function |
| flag_clr | input | 1 | Single-cycle clear for the status flag |
| rst_out | output | 1 | Chip reset, active high |
| bor_flag | output | 1 | Sticky flag: a brown-out reset has occurred |

## Verification
On every cycle, the assertions check the state-level rules. A disabled block in the run state stays there, and a brown-out holds while the supply is low. A dip during the delay sends the block straight back to brown-out. Reset falls only on a delay terminal count, entry sets the flag, and a clear without an entry clears it. Other behaviours depend on exact cycle counts across the synchronizer and the counters: the qualification threshold, the qualification restart after a gap, the full delay length after a restart, and the delay after power-on. Only the bench scenarios can show these, because they measure when `rst_out` changes at the ports.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BROWN = 2'd1,
    ST_DELAY = 2'd2
  } bor_state_t;

  // Cycles in a delay given in milliseconds, with the clock in kHz.
  function automatic int ms_to_cyc(input int clk_khz, input int ms);
    return clk_khz * ms;
  endfunction

  // Cycles in a window given in microseconds, rounded up, never zero.
  function automatic int us_to_cyc(input int clk_khz, input int us);
    int c;
    c = (clk_khz * us + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bor_qual.sv
module bor_qual #(
  parameter int QUAL_CYC = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic arm,
  input  logic low_s,
  output logic hit
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);

  logic [QW-1:0] qcnt;
  logic          counting;

  assign counting = arm && low_s;
  assign hit      = counting && (qcnt == Q_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 qcnt <= '0;
    else if (!counting || hit)  qcnt <= '0;
    else                        qcnt <= qcnt + 1'b1;
  end
endmodule

// File: rtl/bor_delay.sv
module bor_delay #(
  parameter int DELAY_CYC = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  output logic done
);
  localparam int DW = $clog2(DELAY_CYC + 1);
  localparam logic [DW-1:0] D_LAST = DW'(DELAY_CYC - 1);

  logic [DW-1:0] dcnt;

  assign done = run && (dcnt == D_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            dcnt <= '0;
    else if (!run || done) dcnt <= '0;
    else                   dcnt <= dcnt + 1'b1;
  end
endmodule

// File: rtl/bor_sequencer.sv
module bor_sequencer
  import bor_pkg::*;
#(
  parameter int CLK_KHZ   = 1000,
  parameter int DELAY_MS  = 96,
  parameter int QUAL_US   = 50,
  parameter int DELAY_CYC = bor_pkg::ms_to_cyc(CLK_KHZ, DELAY_MS),
  parameter int QUAL_CYC  = bor_pkg::us_to_cyc(CLK_KHZ, QUAL_US)
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low_a,
  input  logic bor_en,
  input  logic flag_clr,
  output logic rst_out,
  output logic bor_flag
);
  bor_state_t st, st_nxt;
  logic low_s;
  logic low_live;
  logic qual_hit;
  logic dly_run;
  logic dly_done;
  logic enter_brown;

  bor_sync #(.STAGES(2)) u_sync (
    .clk(clk), .por_n(por_n), .d_async(supply_low_a), .q_sync(low_s)
  );

  assign low_live = low_s && bor_en;

  bor_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .por_n(por_n), .arm(st == ST_RUN), .low_s(low_live), .hit(qual_hit)
  );

  assign dly_run = (st == ST_DELAY) && !low_live;

  bor_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk(clk), .por_n(por_n), .run(dly_run), .done(dly_done)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_RUN:   if (qual_hit)       st_nxt = ST_BROWN;
      ST_BROWN: if (!low_live)      st_nxt = ST_DELAY;
      ST_DELAY: if (low_live)       st_nxt = ST_BROWN;
                else if (dly_done)  st_nxt = ST_RUN;
      default:                      st_nxt = ST_DELAY;
    endcase
  end

  assign enter_brown = (st_nxt == ST_BROWN) && (st != ST_BROWN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= ST_DELAY;
      bor_flag <= 1'b0;
    end else begin
      st <= st_nxt;
      if (enter_brown)   bor_flag <= 1'b1;
      else if (flag_clr) bor_flag <= 1'b0;
    end
  end

  assign rst_out = (st != ST_RUN);
endmodule

// File: rtl/bor_chk.sv
module bor_chk
  import bor_pkg::*;
#(
  parameter int QUAL_CYC = 4
) (
  input logic       clk,
  input logic       por_n,
  input logic       bor_en,
  input logic       flag_clr,
  input logic       rst_out,
  input logic       bor_flag,
  input bor_state_t st,
  input bor_state_t st_nxt,
  input logic       low_s,
  input logic       dly_done
);
  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_out && !bor_en) |=> !rst_out);

  assert_single_sample_R2: assert property (@(posedge clk) disable iff (!por_n)
    ((QUAL_CYC > 1) && st == ST_RUN && !low_s) |=> (st == ST_RUN));

  assert_hold_low_R3: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_BROWN && low_s && bor_en) |=> (st == ST_BROWN && rst_out));

  assert_entry_flag_R4: assert property (@(posedge clk) disable iff (!por_n)
    (st != ST_BROWN && st_nxt == ST_BROWN) |=> bor_flag);

  assert_release_terminal_R5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out) |-> $past(dly_done));

  assert_redip_return_R6: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_DELAY && low_s && bor_en) |=> (st == ST_BROWN));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    (flag_clr && !(st != ST_BROWN && st_nxt == ST_BROWN)) |=> !bor_flag);
endmodule

bind bor_sequencer bor_chk #(.QUAL_CYC(QUAL_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .bor_en(bor_en), .flag_clr(flag_clr),
  .rst_out(rst_out), .bor_flag(bor_flag), .st(st), .st_nxt(st_nxt),
  .low_s(low_s), .dly_done(dly_done)
);

// File: tb/sim_bor_sequencer.sv
module sim_bor_sequencer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DLY  = 10;
  localparam int  QUAL = 4;
  localparam int  NV   = 19;

  // {en, low, clr, exp_rst, exp_flag, cycles[7:0]}
  localparam logic [12:0] VEC [NV] = '{
    {5'b11_0_00, 8'd5 },  // R2 four samples not yet reached
    {5'b11_0_11, 8'd1 },  // R4 entry on the QUAL-th sample
    {5'b11_0_11, 8'd20},  // R3 held while low
    {5'b10_0_11, 8'd12},  // R5 still in delay
    {5'b10_0_01, 8'd1 },  // R5 released at terminal count
    {5'b10_1_00, 8'd1 },  // R9 flag cleared
    {5'b11_0_00, 8'd3 },  // R2 short pulse
    {5'b10_0_00, 8'd6 },  // R2 short pulse causes no reset
    {5'b11_0_00, 8'd3 },  // R7 first burst
    {5'b10_0_00, 8'd1 },  // R7 one-cycle gap
    {5'b11_0_00, 8'd3 },  // R7 second burst
    {5'b10_0_00, 8'd6 },  // R7 bursts did not add up
    {5'b01_0_00, 8'd30},  // R1 disabled, long low
    {5'b00_0_00, 8'd4 },  // R1 disabled, recovery
    {5'b11_0_11, 8'd6 },  // R4 entry again
    {5'b10_1_10, 8'd8 },  // R9 clear while reset held, delay running
    {5'b11_0_11, 8'd3 },  // R6 redip returns to brown-out
    {5'b10_0_11, 8'd12},  // R6 full delay counted again
    {5'b10_0_01, 8'd1 }   // R6 release after full delay
  };
  localparam int TAG [NV] = '{2,4,3,5,5,9,2,2,7,7,7,7,1,1,4,9,6,6,6};

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_low_a = 1'b0;
  logic bor_en = 1'b1;
  logic flag_clr = 1'b0;
  logic rst_out, bor_flag;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bor_sequencer #(.DELAY_CYC(DLY), .QUAL_CYC(QUAL)) u0 (
    .clk(clk), .por_n(por_n), .supply_low_a(supply_low_a), .bor_en(bor_en),
    .flag_clr(flag_clr), .rst_out(rst_out), .bor_flag(bor_flag)
  );

  task automatic check(input string what, input int req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("rst during por", 8, rst_out, 1'b1);   // R8
    check("flag during por", 8, bor_flag, 1'b0); // R8
    por_n = 1'b1;
    repeat (DLY - 1) @(negedge clk);
    check("rst before delay end", 8, rst_out, 1'b1);
    @(negedge clk);
    check("rst after power-up delay", 8, rst_out, 1'b0);

    for (int i = 0; i < NV; i++) begin
      bor_en       = VEC[i][12];
      supply_low_a = VEC[i][11];
      flag_clr     = VEC[i][10];
      @(negedge clk);
      flag_clr = 1'b0;
      repeat (int'(VEC[i][7:0]) - 1) @(negedge clk);
      check($sformatf("vec %0d rst", i), TAG[i], rst_out, VEC[i][9]);
      check($sformatf("vec %0d flag", i), TAG[i], bor_flag, VEC[i][8]);
    end

    // R8: power-on reset in mid-run restarts the power-up delay
    supply_low_a = 1'b1;
    repeat (8) @(negedge clk);
    check("flag set before por", 4, bor_flag, 1'b1);
    por_n = 1'b0;
    supply_low_a = 1'b0;
    @(negedge clk);
    check("rst on second por", 8, rst_out, 1'b1);
    check("flag cleared by por", 8, bor_flag, 1'b0);
    por_n = 1'b1;
    repeat (DLY - 1) @(negedge clk);
    check("rst before second delay end", 8, rst_out, 1'b1);
    @(negedge clk);
    check("rst after second delay", 8, rst_out, 1'b0);

    finish_up();
  end
endmodule